// File: doc/BRIEF.md
# Time Update Cycle Engine

This block keeps a calendar of seconds, minutes, hours, day of week, day of month, month and two-digit year, and moves it forward by one second each time a once-per-second tick arrives. Every advance runs as a timed cycle. An update-in-progress flag rises first. After a lead interval the registers change. The flag then stays high for a further window and falls, and a one-cycle completion pulse marks the fall. Both intervals are counted in reference-clock enables, so they track the slow reference and not the fast system clock.

Software picks the encoding of every field. It can be packed BCD or plain binary. Hours run either as 0 to 23 or as 1 to 12 with a PM flag in bit 7. A set-inhibit input stops all advances while the host loads new values through a small write port. Day-of-month rollover follows the length of each month, and February gets a leap day in years divisible by four.

Top module: `tuc_core`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00. Day of week, day of month and month read 0x01. The uip output is low.
- R2: A sec_tick seen with set_inh low raises uip in the next cycle. The time fields change exactly LEAD_CYC enabled reference cycles later.
- R3: After the fields change, uip stays high for WIN_CYC more enabled reference cycles and then falls. upd_done is high for exactly the one cycle in which uip first reads low.
- R4: Only cycles with ref_en high advance the lead and window counts. While ref_en is low, uip holds and the fields hold.
- R5: A sec_tick with set_inh high starts no cycle. If set_inh goes high during the lead interval, the cycle is abandoned: uip drops, no field changes and no upd_done follows.
- R6: With bin_mode = 0 each field is two packed BCD digits (tens in bits 7:4), so 0x09 seconds advance to 0x10. With bin_mode = 1 fields are plain binary, so 9 advances to 10 (0x0A).
- R7: Seconds and minutes count 0 to 59. Seconds wrap to 0 and carry into minutes, and minutes wrap to 0 and carry into hours.
- R8: With h24_mode = 1, hours count 0 to 23 and wrap to 0 with a day carry. With h24_mode = 0, hours count 1 to 12 in bits 6:0 with bit 7 set for PM. 11 goes to 12 and toggles PM. 12 goes to 1 and keeps PM. The day carry happens at 11 PM to 12 AM.
- R9: On a day carry, day of week counts 1 to 7 and wraps from 7 to 1.
- R10: On a day carry, day of month wraps to 1 past the month's length, which is 30 for months 4, 6, 9 and 11, 31 for the other months except February, and 29 or 28 for February depending on whether the year is divisible by 4. Month wraps 12 to 1 and carries into the year, and the year wraps 99 to 0.
- R11: A host write with wr_en high loads wr_data into the field chosen by wr_addr in the next cycle. The addresses are 0 seconds, 2 minutes, 4 hours, 6 day of week, 7 day of month, 8 month and 9 year. Writes to any other address change nothing.
- R12: A sec_tick that arrives while uip is high is ignored and does not start a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle enable per reference-clock period |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| set_inh | input | 1 | Inhibits advances while the host sets the time |
| bin_mode | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write field address |
| wr_data | input | 8 | Host write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hr_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| yr_o | output | 8 | Year |
| uip | output | 1 | Update-in-progress flag |
| upd_done | output | 1 | One-cycle pulse as uip falls |

## Verification
The bench builds the block with LEAD_CYC = 2 and WIN_CYC = 3 and holds ref_en high for most of the run, so a full one-second cycle takes only a handful of clocks. Those short intervals make it possible to run a few hundred loaded-and-advanced seconds, mostly seeded just before a rollover, across all four pairings of encoding and hour mode. That covers end-of-month, leap-February, year-wrap and PM-flip cases within the cycle limit. The lead and window lengths are measured by counting cycles of uip against the moment the fields change, so the same checks would scale to the default 8 and 65.

// File: rtl/tuc_pkg.sv
package tuc_pkg;

   localparam int FIELD_W = 8;
   localparam int ADDR_W  = 4;

   localparam logic [ADDR_W-1:0] ADR_SEC = 4'd0;
   localparam logic [ADDR_W-1:0] ADR_MIN = 4'd2;
   localparam logic [ADDR_W-1:0] ADR_HR  = 4'd4;
   localparam logic [ADDR_W-1:0] ADR_DOW = 4'd6;
   localparam logic [ADDR_W-1:0] ADR_DOM = 4'd7;
   localparam logic [ADDR_W-1:0] ADR_MON = 4'd8;
   localparam logic [ADDR_W-1:0] ADR_YR  = 4'd9;

   typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_BUSY} tuc_phase_e;

   typedef struct packed {
      logic [FIELD_W-1:0] sec;
      logic [FIELD_W-1:0] min;
      logic [FIELD_W-1:0] hr;
      logic [FIELD_W-1:0] dow;
      logic [FIELD_W-1:0] dom;
      logic [FIELD_W-1:0] mon;
      logic [FIELD_W-1:0] yr;
   } tuc_time_t;

   // field byte -> binary value
   function automatic logic [6:0] fld_dec(logic [7:0] v, logic bin);
      if (bin) return v[6:0];
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   // binary value -> field byte
   function automatic logic [7:0] fld_enc(logic [6:0] b, logic bin);
      if (bin) return {1'b0, b};
      return {4'(b / 7'd10), 4'(b % 7'd10)};
   endfunction

   function automatic logic [6:0] month_days(logic [6:0] mon, logic [6:0] yr, int leap);
      case (mon)
         7'd2:                     return ((32'(yr) % leap) == 0) ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
         default:                  return 7'd31;
      endcase
   endfunction

endpackage

// File: rtl/tuc_sequencer.sv
module tuc_sequencer
   import tuc_pkg::*;
#(
   parameter int LEAD_CYC = 8,
   parameter int WIN_CYC  = 65
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   input  logic sec_tick,
   input  logic set_inh,
   output logic upd_stb,
   output logic uip,
   output logic upd_done
);
   localparam int CNT_MAX = (LEAD_CYC > WIN_CYC) ? LEAD_CYC : WIN_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);

   generate
      if (LEAD_CYC < 1) begin : g_bad_lead
         $error("LEAD_CYC must be at least 1");
      end
      if (WIN_CYC < 1) begin : g_bad_win
         $error("WIN_CYC must be at least 1");
      end
   endgenerate

   tuc_phase_e       phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         upd_done <= 1'b0;
      end else begin
         upd_done <= 1'b0;
         case (phase_q)
            PH_IDLE: if (sec_tick && !set_inh) begin
               phase_q <= PH_LEAD;
               cnt_q   <= '0;
            end
            PH_LEAD: if (set_inh) begin
               phase_q <= PH_IDLE;
            end else if (ref_en) begin
               if (cnt_q == LEAD_LAST) begin
                  phase_q <= PH_BUSY;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_BUSY: if (ref_en) begin
               if (cnt_q == WIN_LAST) begin
                  phase_q  <= PH_IDLE;
                  upd_done <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign upd_stb = (phase_q == PH_LEAD) && ref_en && !set_inh && (cnt_q == LEAD_LAST);
   assign uip     = (phase_q != PH_IDLE);

   AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> (!uip && $past(uip)));                               // R3
   AST_SET_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!uip && set_inh) |=> !uip);                                      // R5
   AST_STALL_WITHOUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
      (uip && !ref_en && !set_inh) |=> uip);                            // R4
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (uip && sec_tick && !upd_done) |=> !upd_done || !uip);            // R12

endmodule

// File: rtl/tuc_calendar.sv
module tuc_calendar
   import tuc_pkg::*;
#(
   parameter int LEAP_EVERY = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_stb,
   input  logic                bin_mode,
   input  logic                h24_mode,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [FIELD_W-1:0]  wr_data,
   output tuc_time_t           time_q
);
   generate
      if (LEAP_EVERY < 1) begin : g_bad_leap
         $error("LEAP_EVERY must be at least 1");
      end
   endgenerate

   tuc_time_t time_d;

   always_comb begin
      logic [6:0] s, m, h, wd, d, mo, y, mlen;
      logic       pm, c_min, c_hr, c_day, c_mon, c_yr;
      time_d = time_q;
      s  = fld_dec(time_q.sec, bin_mode);
      m  = fld_dec(time_q.min, bin_mode);
      h  = fld_dec(h24_mode ? time_q.hr : {1'b0, time_q.hr[6:0]}, bin_mode);
      pm = time_q.hr[7];
      wd = fld_dec(time_q.dow, bin_mode);
      d  = fld_dec(time_q.dom, bin_mode);
      mo = fld_dec(time_q.mon, bin_mode);
      y  = fld_dec(time_q.yr, bin_mode);
      mlen = month_days(mo, y, LEAP_EVERY);

      c_min = (s >= 7'd59);
      c_hr  = c_min && (m >= 7'd59);
      if (h24_mode) c_day = c_hr && (h >= 7'd23);
      else          c_day = c_hr && pm && (h == 7'd11);
      c_mon = c_day && (d >= mlen);
      c_yr  = c_mon && (mo >= 7'd12);

      if (upd_stb) begin
         time_d.sec = fld_enc(c_min ? 7'd0 : s + 7'd1, bin_mode);
         if (c_min) time_d.min = fld_enc(c_hr ? 7'd0 : m + 7'd1, bin_mode);
         if (c_hr) begin
            if (h24_mode)
               time_d.hr = fld_enc(c_day ? 7'd0 : h + 7'd1, bin_mode);
            else if (h == 7'd11)
               time_d.hr = {~pm, fld_enc(7'd12, bin_mode)[6:0]};
            else if (h >= 7'd12)
               time_d.hr = {pm, fld_enc(7'd1, bin_mode)[6:0]};
            else
               time_d.hr = {pm, fld_enc(h + 7'd1, bin_mode)[6:0]};
         end
         if (c_day) begin
            time_d.dow = fld_enc((wd >= 7'd7) ? 7'd1 : wd + 7'd1, bin_mode);
            time_d.dom = fld_enc(c_mon ? 7'd1 : d + 7'd1, bin_mode);
         end
         if (c_mon) time_d.mon = fld_enc(c_yr ? 7'd1 : mo + 7'd1, bin_mode);
         if (c_yr)  time_d.yr  = fld_enc((y >= 7'd99) ? 7'd0 : y + 7'd1, bin_mode);
      end

      if (wr_en) begin
         case (wr_addr)
            ADR_SEC: time_d.sec = wr_data;
            ADR_MIN: time_d.min = wr_data;
            ADR_HR:  time_d.hr  = wr_data;
            ADR_DOW: time_d.dow = wr_data;
            ADR_DOM: time_d.dom = wr_data;
            ADR_MON: time_d.mon = wr_data;
            ADR_YR:  time_d.yr  = wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                     dom: 8'h01, mon: 8'h01, yr: 8'h00};
      end else begin
         time_q <= time_d;
      end
   end

   AST_SEC_ALWAYS_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !wr_en) |=> (time_q.sec != $past(time_q.sec)));       // R7

endmodule

// File: rtl/tuc_core.sv
module tuc_core
   import tuc_pkg::*;
#(
   parameter int LEAD_CYC   = 8,
   parameter int WIN_CYC    = 65,
   parameter int LEAP_EVERY = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic       sec_tick,
   input  logic       set_inh,
   input  logic       bin_mode,
   input  logic       h24_mode,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hr_o,
   output logic [7:0] dow_o,
   output logic [7:0] dom_o,
   output logic [7:0] mon_o,
   output logic [7:0] yr_o,
   output logic       uip,
   output logic       upd_done
);
   logic      upd_stb;
   tuc_time_t cal_q;

   tuc_sequencer #(.LEAD_CYC(LEAD_CYC), .WIN_CYC(WIN_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_en   (ref_en),
      .sec_tick (sec_tick),
      .set_inh  (set_inh),
      .upd_stb  (upd_stb),
      .uip      (uip),
      .upd_done (upd_done)
   );

   tuc_calendar #(.LEAP_EVERY(LEAP_EVERY)) u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_stb  (upd_stb),
      .bin_mode (bin_mode),
      .h24_mode (h24_mode),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .time_q   (cal_q)
   );

   assign sec_o = cal_q.sec;
   assign min_o = cal_q.min;
   assign hr_o  = cal_q.hr;
   assign dow_o = cal_q.dow;
   assign dom_o = cal_q.dom;
   assign mon_o = cal_q.mon;
   assign yr_o  = cal_q.yr;

   AST_CHANGE_ONLY_IN_UIP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && !$stable(cal_q)) |-> uip);                      // R2

endmodule

// File: tb/tuc_core_bench.sv
module tuc_core_bench;
   localparam int LEAD = 2;
   localparam int WIN  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b1, sec_tick = 1'b0, set_inh = 1'b0;
   logic       bin_mode = 1'b0, h24_mode = 1'b1;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] sec_o, min_o, hr_o, dow_o, dom_o, mon_o, yr_o;
   logic       uip, upd_done;

   tuc_core #(.LEAD_CYC(LEAD), .WIN_CYC(WIN), .LEAP_EVERY(4)) u_tuc_core (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .sec_tick(sec_tick),
      .set_inh(set_inh), .bin_mode(bin_mode), .h24_mode(h24_mode),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .dow_o(dow_o),
      .dom_o(dom_o), .mon_o(mon_o), .yr_o(yr_o), .uip(uip), .upd_done(upd_done));

   always #4 clk = ~clk;

   int  n_chk = 0, n_bad = 0;
   bit  finished = 0;
   int  ms, mm, mh, mw, md, mo, my;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int enc(int v, bit bin);
      return bin ? v : (((v / 10) << 4) | (v % 10));
   endfunction
   function automatic int enc_hr(int h, bit bin, bit h24);
      int h12;
      if (h24) return enc(h, bin);
      h12 = h % 12;
      if (h12 == 0) h12 = 12;
      return enc(h12, bin) | ((h >= 12) ? 128 : 0);
   endfunction
   function automatic int mlen(int m, int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic model_step();
      ms++;
      if (ms < 60) return;
      ms = 0; mm++;
      if (mm < 60) return;
      mm = 0; mh++;
      if (mh < 24) return;
      mh = 0;
      mw = (mw == 7) ? 1 : mw + 1;
      md++;
      if (md <= mlen(mo, my)) return;
      md = 1; mo++;
      if (mo <= 12) return;
      mo = 1;
      my = (my == 99) ? 0 : my + 1;
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load_model();
      set_inh = 1'b1;
      wr(0, enc(ms, bin_mode)); wr(2, enc(mm, bin_mode));
      wr(4, enc_hr(mh, bin_mode, h24_mode)); wr(6, enc(mw, bin_mode));
      wr(7, enc(md, bin_mode)); wr(8, enc(mo, bin_mode)); wr(9, enc(my, bin_mode));
      set_inh = 1'b0;
      @(negedge clk);
   endtask

   task automatic cmp_all(string tag);
      chk({tag, " R7 sec"}, sec_o, enc(ms, bin_mode));
      chk({tag, " R7 min"}, min_o, enc(mm, bin_mode));
      chk({tag, " R8 hr"},  hr_o,  enc_hr(mh, bin_mode, h24_mode));
      chk({tag, " R9 dow"}, dow_o, enc(mw, bin_mode));
      chk({tag, " R10 dom"}, dom_o, enc(md, bin_mode));
      chk({tag, " R10 mon"}, mon_o, enc(mo, bin_mode));
      chk({tag, " R10 yr"},  yr_o,  enc(my, bin_mode));
   endtask

   // one full update cycle; retick pulses sec_tick again inside the window
   task automatic run_second(bit retick);
      logic [7:0] old_s;
      int lead = 0, tot = 0;
      old_s = sec_o;
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      chk("R2 uip rise", uip, 1);
      while (uip && tot < 1000) begin
         if (sec_o == old_s) lead++;
         tot++;
         sec_tick = retick && (tot == LEAD + 1);
         @(negedge clk);
      end
      sec_tick = 1'b0;
      chk("R2 lead cycles", lead, LEAD);
      chk("R3 uip cycles", tot, LEAD + WIN);
      chk("R3 done pulse", upd_done, 1);
      @(negedge clk);
      chk("R3 done width", upd_done, 0);
      chk("R12 no retrigger", uip, 0);
      model_step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R3 watchdog actual=hung expected=idle");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 sec", sec_o, 0); chk("R1 min", min_o, 0); chk("R1 hr", hr_o, 0);
      chk("R1 dow", dow_o, 1); chk("R1 dom", dom_o, 1); chk("R1 mon", mon_o, 1);
      chk("R1 yr", yr_o, 0);   chk("R1 uip", uip, 0);

      // R6 encodings
      bin_mode = 1'b0; h24_mode = 1'b1;
      ms = 9; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0;
      load_model(); run_second(0);
      chk("R6 bcd 09->10", sec_o, 8'h10);
      bin_mode = 1'b1;
      ms = 9; load_model(); run_second(0);
      chk("R6 bin 9->10", sec_o, 8'h0A);

      // R11 write of an unused address changes nothing
      wr(1, 8'h33); wr(15, 8'h44);
      cmp_all("R11 bad addr");

      // R5 set held at tick
      set_inh = 1'b1; sec_tick = 1'b1; @(negedge clk);
      sec_tick = 1'b0; chk("R5 set ignores tick", uip, 0);
      set_inh = 1'b0; @(negedge clk);
      cmp_all("R5 held");

      // R5 set raised during lead
      sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
      chk("R5 lead start", uip, 1);
      set_inh = 1'b1; @(negedge clk);
      chk("R5 abort uip", uip, 0);
      chk("R5 abort done", upd_done, 0);
      set_inh = 1'b0; @(negedge clk);
      chk("R5 abort done later", upd_done, 0);
      cmp_all("R5 abort");

      // R4 stall while ref_en low
      sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0; ref_en = 1'b0;
      repeat (10) @(negedge clk);
      chk("R4 uip held", uip, 1);
      cmp_all("R4 fields held");
      ref_en = 1'b1;
      repeat (LEAD + WIN + 2) @(negedge clk);
      model_step();
      cmp_all("R4 resumed");

      // R12 tick during window
      run_second(1);
      cmp_all("R12");

      // directed: 12h noon / midnight, leap Feb, year wrap
      bin_mode = 1'b0; h24_mode = 1'b0;
      ms = 59; mm = 59; mh = 11; mw = 3; md = 5; mo = 6; my = 20;
      load_model(); run_second(0); cmp_all("R8 noon");
      chk("R8 12pm byte", hr_o, 8'h92);
      ms = 59; mm = 59; mh = 23; mw = 7; md = 28; mo = 2; my = 24;
      load_model(); run_second(0); cmp_all("R10 leap");
      chk("R10 feb29", dom_o, 8'h29);
      chk("R9 wrap", dow_o, 8'h01);
      ms = 59; mm = 59; mh = 23; mw = 2; md = 31; mo = 12; my = 99;
      load_model(); run_second(0); cmp_all("R10 year wrap");

      // random near-rollover seconds over all modes
      for (int i = 0; i < 300; i++) begin
         bin_mode = 1'($urandom);
         h24_mode = 1'($urandom);
         my = $urandom % 100;
         mo = 1 + $urandom % 12;
         md = ($urandom % 2) ? mlen(mo, my) : 1 + $urandom % mlen(mo, my);
         mw = 1 + $urandom % 7;
         mh = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : $urandom % 24;
         mm = ($urandom % 4 != 0) ? 59 : $urandom % 60;
         ms = ($urandom % 4 != 0) ? 59 : $urandom % 60;
         load_model();
         run_second(0);
         cmp_all("rand");
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule